// File: doc/BRIEF.md
# Selectable-Latency Simple Dual-Port RAM

This block is a single-clock RAM with one write port and one read port. Writes always land on the rising clock edge: the clock edge itself acts as the write strobe, so callers never shape a write pulse. A parameter picks how reads are timed. In the two-stage mode the read data is registered twice. In the one-stage mode the array output is captured once and the output register is bypassed. In the half-cycle mode the read request is taken on the falling edge, so the data for an address shows up before the end of the cycle that presents it.

The array can be preloaded from a parameter image at elaboration. The read output still starts at zero after reset in every mode, even when the preloaded words are nonzero. It changes only when a read completes. A synchronous active-low reset clears the read path and leaves the stored words untouched. Typical uses are a lookup table or a buffer where the consumer chooses between timing closure (two stages) and latency (half cycle).

Top module: `dpr_ram`

## Requirements
- R1: After reset, a read of address i returns bits [i*DATA_W +: DATA_W] of the preload image until that address is written.
- R2: When wr_en is high and rst_n is high at a rising edge, wr_data is stored at wr_addr, and any later read of that address returns the new word.
- R3: With READ_MODE = RD_TWO_STAGE, a read sampled (rd_en high) at rising edge k shows its data on rd_data after rising edge k+1.
- R4: With READ_MODE = RD_ONE_STAGE, a read sampled at rising edge k shows its data on rd_data right after edge k.
- R5: With READ_MODE = RD_HALF_CYCLE, rd_en and rd_addr are taken at the falling edge, and the data is on rd_data in the second half of the same cycle.
- R6: A rising edge with rst_n low leaves rd_data at zero in every mode. In half-cycle mode, a falling edge with rst_n low also cancels the pending read.
- R7: rd_data stays zero after reset until the first read completes, even if the preloaded word at address 0 is nonzero.
- R8: A read and a write to the same address in the same cycle return the old word. The new word is returned from the next cycle on.
- R9: While rd_en is low, rd_data holds its last value, even if rd_addr changes or the held address is rewritten.
- R10: Reset does not alter the stored words. wr_en is ignored while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes and most registers use the rising edge. |
| rst_n | input | 1 | Synchronous active-low reset of the read path |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read word, cleared after reset |

## Verification
The hardest case to reach is the same-address collision in half-cycle mode. There, the read taken on the falling edge must still see the old word, because the write lands only on the next rising edge. The bench instantiates all three modes side by side on shared stimulus. It drives a read and a write to one address in a single cycle, then reads that address again in the next cycle. A reset with wr_en held high is also applied mid-stream, and preloaded words are read back afterwards, to show that writes are blocked during reset and that reset leaves the array intact.

// File: rtl/dpr_pkg.sv
// Shared definitions for the selectable-latency dual-port RAM.
// Assumes: nothing beyond a single clock domain.
package dpr_pkg;

    // Read timing choices for the RAM read path
    typedef enum logic [1:0] {
        RD_TWO_STAGE  = 2'd0,
        RD_ONE_STAGE  = 2'd1,
        RD_HALF_CYCLE = 2'd2
    } read_mode_e;

endpackage

// File: rtl/dpr_mem_array.sv
// Storage array with one rising-edge write port and one combinational
// read port. The preload image is applied at elaboration.
// Assumes: the caller gates the write request with reset.
module dpr_mem_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2**ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Apply the preload image at elaboration
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            store[i] = INIT_IMAGE[i*DATA_W +: DATA_W];
        end
    end

    // Commit a write on the rising edge
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Combinational read of the current contents
    assign rdata = store[raddr];

endmodule

// File: rtl/dpr_read_sync.sv
// Rising-edge read path: captures the array word when a read is
// requested. With TWO_STAGE set, it adds an output register that loads
// one edge later.
// Assumes: arr_data reflects rd_addr before the rising edge.
module dpr_read_sync #(
    parameter int DATA_W    = 8,
    parameter bit TWO_STAGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cap_q;

    // First stage: take the array word on a read request, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (rd_en) begin
            cap_q <= arr_data;
        end
    end

    generate
        if (TWO_STAGE) begin : g_two
            logic              cap_vld_q;
            logic [DATA_W-1:0] out_q;

            // Track which first-stage loads were real reads
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap_vld_q <= 1'b0;
                end else begin
                    cap_vld_q <= rd_en;
                end
            end

            // Second stage: forward a completed read, else hold
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else if (cap_vld_q) begin
                    out_q <= cap_q;
                end
            end

            assign rd_data = out_q;
        end else begin : g_one
            assign rd_data = cap_q;
        end
    endgenerate

endmodule

// File: rtl/dpr_read_half.sv
// Half-cycle read path. The read request is taken on the falling edge
// and the array word passes straight to the output. A rising-edge
// register keeps the last word shown, for the cycles without a read.
// Assumes: rd_en and rd_addr are settled before the falling edge.
module dpr_read_half #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] keep_q;

    // Falling-edge capture of the read request
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            req_q  <= rd_en;
            addr_q <= rd_addr;
        end
    end

    // Keep the shown word so it survives idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (req_q) begin
            keep_q <= arr_data;
        end
    end

    assign arr_addr = addr_q;
    assign rd_data  = req_q ? arr_data : keep_q;

endmodule

// File: rtl/dpr_ram.sv
// Top of the selectable-latency simple dual-port RAM. It gates writes
// with reset and builds the read path that READ_MODE selects.
// Assumes: single clock, synchronous active-low reset.
module dpr_ram
    import dpr_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         ADDR_W    = 5,
    parameter read_mode_e READ_MODE = RD_TWO_STAGE,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_rdata;
    logic              wr_go;

    // Writes are blocked while reset is held
    assign wr_go = wr_en & rst_n;

    dpr_mem_array #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_array (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    generate
        if (READ_MODE == RD_HALF_CYCLE) begin : g_half
            dpr_read_half #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W)
            ) u_rd (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_en    (rd_en),
                .rd_addr  (rd_addr),
                .arr_data (arr_rdata),
                .arr_addr (arr_raddr),
                .rd_data  (rd_data)
            );
        end else begin : g_sync
            assign arr_raddr = rd_addr;
            dpr_read_sync #(
                .DATA_W    (DATA_W),
                .TWO_STAGE (READ_MODE == RD_TWO_STAGE)
            ) u_rd (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_en    (rd_en),
                .arr_data (arr_rdata),
                .rd_data  (rd_data)
            );
        end
    endgenerate

endmodule

// File: rtl/dpr_ram_chk.sv
// Port-level timing checks for dpr_ram, attached by bind.
// Assumes: rd_en changes away from the falling edge.
module dpr_ram_chk
    import dpr_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter read_mode_e READ_MODE = RD_TWO_STAGE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data
);
    AST_RESET_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0)); // R6

    generate
        if (READ_MODE == RD_TWO_STAGE) begin : g_two
            AST_TWO_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rd_en) |=> $stable(rd_data)); // R9
            AST_TWO_STAGE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                (!$stable(rd_data) && $past(rst_n)) |-> $past(rd_en, 2)); // R3
        end else if (READ_MODE == RD_ONE_STAGE) begin : g_one
            AST_ONE_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en |=> $stable(rd_data)); // R9
            AST_ONE_STAGE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                (!$stable(rd_data) && $past(rst_n)) |-> $past(rd_en)); // R4
        end else begin : g_half
            AST_HALF_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_en && !$past(rd_en) && $past(rst_n)) |-> $stable(rd_data)); // R9
        end
    endgenerate

endmodule

bind dpr_ram dpr_ram_chk #(
    .DATA_W    (DATA_W),
    .READ_MODE (READ_MODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_data)
);

// File: tb/sim_dpr_ram.sv
// Directed bench: all three read modes run side by side on shared inputs
// and are compared against a bench-side model.
module sim_dpr_ram;
    import dpr_pkg::*;

    localparam int DW    = 8;
    localparam int AW    = 5;
    localparam int DEPTH = 2**AW;

    function automatic logic [DEPTH*DW-1:0] make_image();
        logic [DEPTH*DW-1:0] img;
        for (int i = 0; i < DEPTH; i++) begin
            img[i*DW +: DW] = DW'((i * 59) ^ 255);
        end
        return img;
    endfunction

    localparam logic [DEPTH*DW-1:0] IMG = make_image();

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] q_two, q_one, q_half;

    always #2 clk = ~clk;

    dpr_ram #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_TWO_STAGE), .INIT_IMAGE(IMG)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_two));
    dpr_ram #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_ONE_STAGE), .INIT_IMAGE(IMG)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_one));
    dpr_ram #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_HALF_CYCLE), .INIT_IMAGE(IMG)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_half));

    // bench model state
    logic [DW-1:0] model_mem [DEPTH];
    logic [DW-1:0] m_one, m_cap, m_two, m_keep;
    logic          m_cap_vld;
    int            total = 0, fails = 0;
    bit            done = 1'b0;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock cycle: drive, check mid-cycle after the falling edge, update model
    task automatic cyc(input logic r, input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic re, input logic [AW-1:0] ra,
                       input string tag);
        logic [DW-1:0] exp_half;
        #1;
        rst_n = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #2;
        exp_half = (r && re) ? model_mem[ra] : m_keep;
        check(q_two,  m_two,    {tag, " R3 two-stage"});
        check(q_one,  m_one,    {tag, " R4 one-stage"});
        check(q_half, exp_half, {tag, " R5 half-cycle"});
        @(posedge clk);
        if (!r) begin
            m_one = '0; m_cap = '0; m_cap_vld = 1'b0; m_two = '0; m_keep = '0;
        end else begin
            if (m_cap_vld) m_two = m_cap;
            if (re) begin
                m_cap = model_mem[ra]; m_one = model_mem[ra]; m_keep = model_mem[ra];
            end
            m_cap_vld = re;
            if (we) model_mem[wa] = wd;
        end
    endtask

    task automatic t_reset_state();   // R6 R7
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R7 idle after reset");
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd0, "R7 first read of 0xFF word");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R7 drain");
    endtask

    task automatic t_preload();       // R1
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, '0, '0, 1'b1, AW'(i), "R1 preload stream");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R1 drain");
    endtask

    task automatic t_write_read();    // R2
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, AW'(i * 3), DW'(8'hA0 + i), 1'b0, '0, "R2 write");
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, '0, 1'b1, AW'(i * 3), "R2 read back");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R2 drain");
    endtask

    task automatic t_collision();     // R8
        cyc(1'b1, 1'b1, 5'd7, 8'h5C, 1'b1, 5'd7, "R8 same-address read/write");
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd7, "R8 read after collision");
        cyc(1'b1, 1'b1, 5'd9, 8'hC3, 1'b1, 5'd9, "R8 second collision");
        cyc(1'b1, 1'b1, 5'd9, 8'h3C, 1'b1, 5'd9, "R8 back-to-back collision");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd9, "R8 settle");
    endtask

    task automatic t_hold();          // R9
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd4, "R9 load");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 5'd4, DW'(8'h11 * i), 1'b0, AW'(i + 10), "R9 idle with rewrite");
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd4, "R9 reread");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, 5'd20, "R9 drain");
    endtask

    task automatic t_reset_mid();     // R6 R10
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd12, "R6 read before reset");
        cyc(1'b1, 1'b0, '0, '0, 1'b1, 5'd13, "R6 read before reset");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, AW'(i + 12), 8'hEE, 1'b1, AW'(i + 12), "R10 reset with write");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R6 cleared after reset");
        for (int i = 12; i < 16; i++) cyc(1'b1, 1'b0, '0, '0, 1'b1, AW'(i), "R10 contents kept");
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, '0, '0, 1'b0, '0, "R10 drain");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = IMG[i*DW +: DW];
        m_one = '0; m_cap = '0; m_two = '0; m_keep = '0; m_cap_vld = 1'b0;
        repeat (3) @(posedge clk);
        t_reset_state();
        t_preload();
        t_write_read();
        t_collision();
        t_hold();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule